// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block produces the byte that a flash-style memory returns on reads while one of its self-timed operations is running. A command decoder elsewhere sends a one-cycle start pulse together with the operation kind: byte program, sector erase or whole-array erase. For a program it also sends the byte being written. From that edge the block holds a busy flag for a fixed, parameterised number of clock cycles. These counts stand in for the long program and erase times of the cell array.

Software finds out when the operation has finished in one of two ways, and both work at once. The first is the top data bit. While busy, it reads as the inverse of the top bit of the value being written. An erase writes all ones, so this bit reads 0 during an erase. Once the operation ends, the bit shows the real stored value. The second is the bit just below it, which flips on every read strobe taken during the operation. When the operation ends, reads return the array contents unchanged and that bit stops moving.

The array itself and the command-sequence decoding are outside this block. The current array byte comes in on an input and is passed through or partly overlaid.

Top module: `opstat_reporter`

## Requirements
- R1: Reset clears `busy`. A start pulse taken while idle, with `op_kind` equal to 2'b00 (program), 2'b01 (sector erase) or 2'b10 (chip erase), raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES cycles respectively.
- R2: A start pulse with `op_kind` equal to 2'b11 is ignored: `busy` stays low.
- R3: A start pulse that arrives while `busy` is high is ignored. The running operation keeps its remaining length, its poll bit and its toggle state.
- R4: While a program is busy, `rd_data[7]` equals the inverse of `wr_byte[7]` as sampled on the accepted start cycle.
- R5: While an erase of either kind is busy, `rd_data[7]` reads 0.
- R6: Each accepted start sets the toggle bit `rd_data[6]` to 0, so the first read of every operation returns 0 in bit 6.
- R7: While busy, `rd_data[6]` inverts after every cycle in which `rd_en` is high. Cycles with `rd_en` low leave it unchanged.
- R8: While busy, `rd_data[5:0]` equals `arr_data[5:0]`.
- R9: While `busy` is low, `rd_data` equals `arr_data` on all 8 bits. This covers the state after completion and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle pulse at the final write strobe of a command |
| op_kind | input | 2 | Operation: 00 program, 01 sector erase, 10 chip erase, 11 none |
| wr_byte | input | 8 | Byte being programmed (sampled with an accepted start) |
| rd_en | input | 1 | Read strobe; one cycle high per read access |
| arr_data | input | 8 | Current array byte at the read address |
| busy | output | 1 | High while the timed operation runs |
| rd_data | output | 8 | Byte returned to the reader |

## Verification
Some properties are checked by assertions on every cycle:
- the toggle bit flips on every busy read and holds on every busy non-read;
- the poll bit is the inverse of the written bit for programs and 0 for erases, and holds steady for the whole operation;
- an accepted start raises busy with the toggle at 0;
- idle reads pass the array through.

The exact busy length for each operation kind needs the bench's sweeps. So does the rejection of the unused kind code and of starts during busy. These sweeps cover every kind, several written bytes, and read patterns of every cycle, alternate cycles and none at all.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_NONE = 2'b11
  } op_kind_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/opstat_timer.sv
module opstat_timer
  import opstat_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 1000,
  parameter int unsigned SECT_CYCLES = 500000,
  parameter int unsigned CHIP_CYCLES = 100000000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  op_kind_e kind,
  output logic     busy
);

  localparam int unsigned MAXC = max3(PROG_CYCLES, SECT_CYCLES, CHIP_CYCLES);
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (kind)
      OP_SECT: load_val = CW'(SECT_CYCLES - 1);
      OP_CHIP: load_val = CW'(CHIP_CYCLES - 1);
      default: load_val = CW'(PROG_CYCLES - 1);
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (launch) begin
        busy_d = 1'b1;
        cnt_d  = load_val;
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic busy,
  input  logic rd_en,
  output logic tog
);

  logic tog_q, tog_d, tog_en;

  assign tog_en = launch | (busy & rd_en);

  always_comb begin
    tog_d = tog_q;
    if (launch) begin
      tog_d = 1'b0;
    end else if (busy && rd_en) begin
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

  assign tog = tog_q;

endmodule

// File: rtl/opstat_poll.sv
module opstat_poll
  import opstat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  op_kind_e kind,
  input  logic     data_msb,
  output logic     poll
);

  logic poll_q, poll_d;

  always_comb begin
    if (kind == OP_PROG) begin
      poll_d = ~data_msb;
    end else begin
      poll_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
    end else if (launch) begin
      poll_q <= poll_d;
    end
  end

  assign poll = poll_q;

endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
  import opstat_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROG_CYCLES = 1000,
  parameter int unsigned SECT_CYCLES = 500000,
  parameter int unsigned CHIP_CYCLES = 100000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TOG_BIT  = DATA_W - 2;

  op_kind_e kind;
  logic     launch;
  logic     busy_w;
  logic     tog_w;
  logic     poll_w;
  logic     unused_wr_low;

  assign kind          = op_kind_e'(op_kind);
  assign launch        = start & ~busy_w & (kind != OP_NONE);
  assign unused_wr_low = ^wr_byte[DATA_W-2:0];

  opstat_timer #(
    .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES),
    .CHIP_CYCLES(CHIP_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .kind  (kind),
    .busy  (busy_w)
  );

  opstat_toggle u_toggle (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .busy  (busy_w),
    .rd_en (rd_en),
    .tog   (tog_w)
  );

  opstat_poll u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .kind    (kind),
    .data_msb(wr_byte[POLL_BIT]),
    .poll    (poll_w)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_out
    if (b == POLL_BIT) begin : g_poll
      assign rd_data[b] = busy_w ? poll_w : arr_data[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign rd_data[b] = busy_w ? tog_w : arr_data[b];
    end else begin : g_pass
      assign rd_data[b] = arr_data[b];
    end
  end

  assign busy = busy_w;

endmodule

// File: rtl/opstat_reporter_chk.sv
module opstat_reporter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        op_kind,
  input logic [DATA_W-1:0] wr_byte,
  input logic              rd_en,
  input logic [DATA_W-1:0] arr_data,
  input logic              busy,
  input logic [DATA_W-1:0] rd_data
);

  logic accept;
  assign accept = start && !busy && (op_kind != 2'b11);

  a_r1_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r2_bad_kind_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op_kind == 2'b11) |=> !busy);

  a_r4_prog_poll_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == 2'b00) |=> rd_data[DATA_W-1] == !$past(wr_byte[DATA_W-1]));

  a_r5_erase_poll_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind != 2'b00) |=> !rd_data[DATA_W-1]);

  a_r3_poll_steady: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || rd_data[DATA_W-1] == $past(rd_data[DATA_W-1])));

  a_r6_toggle_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rd_data[DATA_W-2]);

  a_r7_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (!busy || rd_data[DATA_W-2] != $past(rd_data[DATA_W-2])));

  a_r7_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_en) |=> (!busy || rd_data[DATA_W-2] == $past(rd_data[DATA_W-2])));

  a_r8_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_data[DATA_W-3:0] == arr_data[DATA_W-3:0]);

  a_r9_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_data == arr_data);

endmodule

bind opstat_reporter opstat_reporter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .op_kind (op_kind),
  .wr_byte (wr_byte),
  .rd_en   (rd_en),
  .arr_data(arr_data),
  .busy    (busy),
  .rd_data (rd_data)
);

// File: tb/tb_opstat_reporter.sv
module tb_opstat_reporter;

  localparam int CLK_PERIOD = 10;
  localparam int P_CYC = 5;
  localparam int S_CYC = 9;
  localparam int C_CYC = 14;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [1:0] op_kind;
  logic [7:0] wr_byte;
  logic       rd_en;
  logic [7:0] arr_data;
  logic       busy;
  logic [7:0] rd_data;

  int vectors;
  int errors;
  bit done;

  bit m_busy;
  int m_left;
  bit m_tog;
  bit m_poll;

  opstat_reporter #(
    .DATA_W(8),
    .PROG_CYCLES(P_CYC),
    .SECT_CYCLES(S_CYC),
    .CHIP_CYCLES(C_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .wr_byte(wr_byte), .rd_en(rd_en), .arr_data(arr_data),
    .busy(busy), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int dur_of(input logic [1:0] k);
    case (k)
      2'b01:   return S_CYC;
      2'b10:   return C_CYC;
      default: return P_CYC;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit st, input logic [1:0] k, input logic [7:0] d,
                      input bit rd, input logic [7:0] arr, input string breq);
    logic [7:0] exp;
    @(negedge clk);
    start = st; op_kind = k; wr_byte = d; rd_en = rd; arr_data = arr;
    #1;
    check(breq, {7'd0, busy}, {7'd0, m_busy});
    if (m_busy) begin
      check("R4/R5 poll bit", {7'd0, rd_data[7]}, {7'd0, m_poll});
      check("R6/R7 toggle bit", {7'd0, rd_data[6]}, {7'd0, m_tog});
      check("R8 low bits", {2'd0, rd_data[5:0]}, {2'd0, arr[5:0]});
    end else begin
      exp = arr;
      check("R9 idle data", rd_data, exp);
    end
    @(posedge clk);
    if (!m_busy) begin
      if (st && k != 2'b11) begin
        m_busy = 1'b1;
        m_left = dur_of(k);
        m_tog  = 1'b0;
        m_poll = (k == 2'b00) ? ~d[7] : 1'b0;
      end
    end else begin
      if (rd) m_tog = ~m_tog;
      m_left--;
      if (m_left == 0) m_busy = 1'b0;
    end
  endtask

  initial begin
    vectors = 0; errors = 0; done = 0;
    m_busy = 0; m_left = 0; m_tog = 0; m_poll = 0;
    rst_n = 1'b0; start = 0; op_kind = 0; wr_byte = 0; rd_en = 0; arr_data = 8'h3C;
    #(CLK_PERIOD * 3);
    #1;
    check("R1 reset busy", {7'd0, busy}, 8'd0);
    check("R9 reset data", rd_data, 8'h3C);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      for (int di = 0; di < 4; di++) begin
        for (int pat = 0; pat < 4; pat++) begin
          logic [7:0] d;
          logic [7:0] arr;
          int n;
          string breq;
          d = (di == 0) ? 8'h00 : (di == 1) ? 8'h80 : (di == 2) ? 8'h5A : 8'hA5;
          breq = (k == 3) ? "R2 busy" : (pat == 3) ? "R3 busy" : "R1 busy";
          n = dur_of(k[1:0]) + 4;
          step(1'b1, k[1:0], d, 1'b0, 8'h11, breq);
          for (int c = 0; c < n; c++) begin
            bit rd;
            bit st;
            arr = (k == 1 || k == 2) && c >= dur_of(k[1:0]) ? 8'hFF
                                                             : 8'(c * 37 + di * 11 + pat);
            rd = (pat == 0) ? 1'b1 : (pat == 1) ? c[0] : (pat == 2) ? 1'b0 : ~c[0];
            st = (pat == 3) && (c == 2);
            step(st, 2'(k + 1), ~d, rd, arr, breq);
          end
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule